// File: doc/BRIEF.md
# UART receive FIFO with trigger

This block is the character store on the receive side of a memory-mapped serial port. Characters reach it from two places. The first is the line receiver, which supplies a byte, its error flags and break events. The second is the transmit path when internal loopback is switched on. A bus read of the data register takes characters out one at a time. Each stored entry carries the data byte, the receive error flags and a break marker. The block tracks its contents with a read pointer and an occupancy count.

The FIFO enable bit of the line control register selects the storage size at run time. When the bit is set, the full array is in use. When it is clear, the block acts as a single holding register. A change of that bit flushes the store.

The block reports full, empty and free-space status, and it drives a receive interrupt status bit. That bit is raised only when a character brings the count to exactly the trigger level. It is dropped only when a read leaves the count exactly one below that level. Each read latches the flags of the character being read into a receive status output.

Top module: `uart_rxq`

## Requirements
- R1: The effective depth is DEPTH (16 by default) while `fifo_mode_i` is applied and 1 while it is not. `free_o` equals the effective depth minus the occupancy. After reset the block is in single-slot mode with `free_o`=1, `empty_o`=1, `full_o`=0, `rx_irq_o`=0, `rsr_o`=0 and `rd_data_o`=0.
- R2: Characters come out in the order they went in. This holds across the wrap from the last slot back to slot 0. `rd_data_o` always shows the entry at the read pointer.
- R3: `empty_o` is high exactly when the occupancy is zero. `full_o` is high exactly when the occupancy equals the effective depth.
- R4: A character that arrives while the store is full, with no read in the same cycle, is dropped. Neither the occupancy nor the stored entries change.
- R5: A read of an empty store leaves the pointer and the occupancy unchanged. `rd_data_o` keeps showing the stale entry at the read pointer.
- R6: With TRIG_LVL=1, `rx_irq_o` rises in the cycle after a character brings the occupancy to the trigger level. Further arrivals keep it high. It falls only after a read that leaves the occupancy at TRIG_LVL−1, and this includes a read of an empty store.
- R7: A change of `fifo_mode_i` from its registered value flushes the store. One cycle later the occupancy and read pointer are zero and the new depth applies. A character offered in the flush cycle is discarded. `rx_irq_o` is not changed by the flush.
- R8: While `loopback_i` is high, line characters and line breaks are ignored, and `tx_push_i` stores `tx_data_i` with all flags zero. While `loopback_i` is low, `tx_push_i` stores nothing.
- R9: A line break with loopback off stores one entry with data 0 and the break marker set. If a line character arrives in the same cycle, the character is discarded.
- R10: A read loads `rsr_o` with the flags of the entry read. Bit 3 holds the break marker and bits 2:0 hold the error flags. `rsr_clr_i` clears `rsr_o` and wins over a read in the same cycle.
- R11: A character and a read in the same cycle both take effect, even when the store is full. The occupancy stays the same and the new character is placed after the existing ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | FIFO enable bit from line control; 1 selects the full depth |
| loopback_i | input | 1 | Internal loopback enable |
| line_push_i | input | 1 | Line receiver offers a character |
| line_data_i | input | 8 | Received data byte |
| line_err_i | input | 3 | Receive error flags of that byte |
| line_brk_i | input | 1 | Line break event |
| tx_push_i | input | 1 | Data register write for transmission |
| tx_data_i | input | 8 | Transmitted byte |
| pop_i | input | 1 | Data register read |
| rsr_clr_i | input | 1 | Receive status clear |
| rd_data_o | output | 8 | Data byte at the read pointer |
| rsr_o | output | 4 | Flags of the last read character: {break, error[2:0]} |
| full_o | output | 1 | Store full |
| empty_o | output | 1 | Store empty |
| free_o | output | 5 | Free slots at the current depth |
| rx_irq_o | output | 1 | Receive interrupt status |

## Verification
A read pointer or occupancy that drifts from the true state shows up on `rd_data_o` at the next read, as a byte out of order or a repeated byte. It also shows on `free_o` and the flags one cycle after the push or read that corrupted it. A missed flush leaves `free_o` below the new depth on the cycle after the mode change. A wrong trigger comparison leaves `rx_irq_o` high after the store drains, or low after the first arrival, in both cases within one cycle. Loopback and break routing faults appear as a changed `free_o`, or as a wrong `rsr_o` after the following read.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
   parameter int unsigned RXQ_DATA_W = 8;
   parameter int unsigned RXQ_ERR_W  = 3;

   // one stored character: break marker, line error flags, data byte
   typedef struct packed {
      logic                  brk;
      logic [RXQ_ERR_W-1:0]  err;
      logic [RXQ_DATA_W-1:0] data;
   } rxq_ent_t;
endpackage

// File: rtl/uart_rxq_src.sv
module uart_rxq_src
   import uart_rxq_pkg::*;
(
   input  logic                  loopback_i,
   input  logic                  line_push_i,
   input  logic [RXQ_DATA_W-1:0] line_data_i,
   input  logic [RXQ_ERR_W-1:0]  line_err_i,
   input  logic                  line_brk_i,
   input  logic                  tx_push_i,
   input  logic [RXQ_DATA_W-1:0] tx_data_i,
   output logic                  push_o,
   output rxq_ent_t              ent_o
);
   // loopback cuts the line off completely; break beats a plain character
   always_comb begin
      push_o = 1'b0;
      ent_o  = '0;
      if (loopback_i) begin
         if (tx_push_i) begin
            push_o     = 1'b1;
            ent_o.data = tx_data_i;
         end
      end else if (line_brk_i) begin
         push_o    = 1'b1;
         ent_o.brk = 1'b1;
      end else if (line_push_i) begin
         push_o     = 1'b1;
         ent_o.data = line_data_i;
         ent_o.err  = line_err_i;
      end
   end
endmodule

// File: rtl/uart_rxq_mem.sv
module uart_rxq_mem
   import uart_rxq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [PTR_W-1:0] wslot_i,
   input  rxq_ent_t         wdata_i,
   input  logic [PTR_W-1:0] rptr_i,
   output rxq_ent_t         rdata_o
);
   rxq_ent_t slot_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else if (wr_en_i) begin
         slot_q[wslot_i] <= wdata_i;
      end
   end

   assign rdata_o = slot_q[rptr_i];
endmodule

// File: rtl/uart_rxq_ctl.sv
module uart_rxq_ctl #(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned TRIG_LVL = 1,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_mode_i,
   input  logic             push_i,
   input  logic             pop_i,
   output logic             mode_q_o,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wslot_o,
   output logic [PTR_W-1:0] rptr_o,
   output logic             full_o,
   output logic             empty_o,
   output logic [CNT_W-1:0] free_o,
   output logic             irq_o
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W:0]   TRIG_C  = (CNT_W + 1)'(TRIG_LVL);
   localparam logic [PTR_W-1:0] WRAP_C  = PTR_W'(DEPTH - 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("uart_rxq_ctl: DEPTH must be a power of two, at least 2");
      if (TRIG_LVL < 1 || TRIG_LVL > DEPTH)
         $error("uart_rxq_ctl: TRIG_LVL must lie in 1..DEPTH");
   endgenerate

   logic             mode_q;
   logic [PTR_W-1:0] rptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;

   logic [CNT_W-1:0] eff;
   logic [PTR_W-1:0] mask;
   logic             flush, pop_take, push_take, irq_set, irq_clr;
   logic [CNT_W-1:0] cnt_pop, cnt_nxt;

   always_comb begin
      eff       = mode_q ? DEPTH_C : CNT_W'(1);
      mask      = mode_q ? WRAP_C : '0;
      flush     = fifo_mode_i ^ mode_q;
      pop_take  = pop_i & ~flush & (cnt_q != '0);
      push_take = push_i & ~flush & ((cnt_q != eff) | pop_take);
      cnt_pop   = cnt_q - CNT_W'(pop_take);
      cnt_nxt   = cnt_pop + CNT_W'(push_take);
      // read is ordered before the arriving character within one cycle
      irq_clr   = pop_i & ~flush & (({1'b0, cnt_pop} + (CNT_W + 1)'(1)) == TRIG_C);
      irq_set   = push_take & ({1'b0, cnt_nxt} == TRIG_C);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         rptr_q <= '0;
         cnt_q  <= '0;
         irq_q  <= 1'b0;
      end else begin
         mode_q <= fifo_mode_i;
         irq_q  <= irq_set | (irq_q & ~irq_clr);
         if (flush) begin
            rptr_q <= '0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_nxt;
            if (pop_take) rptr_q <= (rptr_q + PTR_W'(1)) & mask;
         end
      end
   end

   assign mode_q_o = mode_q;
   assign wr_en_o  = push_take;
   assign wslot_o  = (rptr_q + cnt_q[PTR_W-1:0]) & mask;
   assign rptr_o   = rptr_q;
   assign full_o   = (cnt_q == eff);
   assign empty_o  = (cnt_q == '0);
   assign free_o   = eff - cnt_q;
   assign irq_o    = irq_q;
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
   import uart_rxq_pkg::*;
#(
   parameter int unsigned DEPTH    = 16,
   parameter int unsigned TRIG_LVL = 1,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fifo_mode_i,
   input  logic                    loopback_i,
   input  logic                    line_push_i,
   input  logic [RXQ_DATA_W-1:0]   line_data_i,
   input  logic [RXQ_ERR_W-1:0]    line_err_i,
   input  logic                    line_brk_i,
   input  logic                    tx_push_i,
   input  logic [RXQ_DATA_W-1:0]   tx_data_i,
   input  logic                    pop_i,
   input  logic                    rsr_clr_i,
   output logic [RXQ_DATA_W-1:0]   rd_data_o,
   output logic [RXQ_ERR_W:0]      rsr_o,
   output logic                    full_o,
   output logic                    empty_o,
   output logic [CNT_W-1:0]        free_o,
   output logic                    rx_irq_o
);
   logic             push;
   rxq_ent_t         ent, head;
   logic             mode_q, wr_en;
   logic [PTR_W-1:0] wslot, rptr;
   logic [RXQ_ERR_W:0] rsr_q;

   uart_rxq_src u_src (
      .loopback_i (loopback_i),
      .line_push_i(line_push_i),
      .line_data_i(line_data_i),
      .line_err_i (line_err_i),
      .line_brk_i (line_brk_i),
      .tx_push_i  (tx_push_i),
      .tx_data_i  (tx_data_i),
      .push_o     (push),
      .ent_o      (ent)
   );

   uart_rxq_ctl #(.DEPTH(DEPTH), .TRIG_LVL(TRIG_LVL)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_mode_i(fifo_mode_i),
      .push_i     (push),
      .pop_i      (pop_i),
      .mode_q_o   (mode_q),
      .wr_en_o    (wr_en),
      .wslot_o    (wslot),
      .rptr_o     (rptr),
      .full_o     (full_o),
      .empty_o    (empty_o),
      .free_o     (free_o),
      .irq_o      (rx_irq_o)
   );

   uart_rxq_mem #(.DEPTH(DEPTH)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en_i(wr_en),
      .wslot_i(wslot),
      .wdata_i(ent),
      .rptr_i (rptr),
      .rdata_o(head)
   );

   // receive status: flags of the character last read, clear has priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rsr_q <= '0;
      else if (rsr_clr_i) rsr_q <= '0;
      else if (pop_i)     rsr_q <= {head.brk, head.err};
   end

   assign rd_data_o = head.data;
   assign rsr_o     = rsr_q;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_mode_i,
   input logic             mode_q,
   input logic             loopback_i,
   input logic             line_push_i,
   input logic             line_brk_i,
   input logic             tx_push_i,
   input logic             pop_i,
   input logic             rsr_clr_i,
   input logic             full_o,
   input logic             empty_o,
   input logic [CNT_W-1:0] free_o,
   input logic             rx_irq_o,
   input logic [3:0]       rsr_o
);
   logic any_in;
   assign any_in = line_push_i | line_brk_i | tx_push_i;

   AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      free_o <= (mode_q ? CNT_W'(DEPTH) : CNT_W'(1)));  // R1
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !empty_o);  // R3
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && any_in && !pop_i && fifo_mode_i == mode_q) |=> full_o);  // R4
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && pop_i && !any_in) |=> empty_o);  // R5
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq_o) |-> $past(any_in));  // R6
   AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode_i != mode_q) |=> (empty_o && mode_q == $past(fifo_mode_i)));  // R7
   AST_LOOP_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (loopback_i && !tx_push_i && !pop_i && fifo_mode_i == mode_q) |=> $stable(free_o));  // R8
   AST_RSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rsr_clr_i |=> (rsr_o == 4'd0));  // R10
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_mode_i(fifo_mode_i),
   .mode_q     (mode_q),
   .loopback_i (loopback_i),
   .line_push_i(line_push_i),
   .line_brk_i (line_brk_i),
   .tx_push_i  (tx_push_i),
   .pop_i      (pop_i),
   .rsr_clr_i  (rsr_clr_i),
   .full_o     (full_o),
   .empty_o    (empty_o),
   .free_o     (free_o),
   .rx_irq_o   (rx_irq_o),
   .rsr_o      (rsr_o)
);

// File: tb/test_uart_rxq.sv
module test_uart_rxq;
   localparam int DEPTH = 16;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic fifo_mode_i = 0, loopback_i = 0, line_push_i = 0, line_brk_i = 0;
   logic tx_push_i = 0, pop_i = 0, rsr_clr_i = 0;
   logic [7:0] line_data_i = 0, tx_data_i = 0;
   logic [2:0] line_err_i = 0;
   logic [7:0] rd_data_o;
   logic [3:0] rsr_o;
   logic full_o, empty_o, rx_irq_o;
   logic [CNT_W-1:0] free_o;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   uart_rxq #(.DEPTH(DEPTH), .TRIG_LVL(1)) i_uart_rxq (.*);

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push_line(input logic [7:0] d, input logic [2:0] e);
      line_push_i = 1; line_data_i = d; line_err_i = e;
      step();
      line_push_i = 0; line_err_i = 0;
   endtask

   task automatic pop_expect(input logic [7:0] d, input string req);
      chk(req, rd_data_o, d);
      pop_i = 1;
      step();
      pop_i = 0;
   endtask

   task automatic t_reset_state;
      chk("R1 reset free", free_o, 1);
      chk("R1 reset empty", empty_o, 1);
      chk("R1 reset full", full_o, 0);
      chk("R1 reset irq", rx_irq_o, 0);
      chk("R1 reset rsr", rsr_o, 0);
      chk("R1 reset data", rd_data_o, 0);
   endtask

   task automatic t_single_slot;
      push_line(8'h41, 3'd0);
      chk("R3 single full", full_o, 1);
      chk("R1 single free", free_o, 0);
      chk("R6 irq after first", rx_irq_o, 1);
      push_line(8'h42, 3'd0);
      chk("R4 drop free", free_o, 0);
      pop_expect(8'h41, "R4 drop keeps head");
      chk("R3 empty after pop", empty_o, 1);
      chk("R6 irq cleared", rx_irq_o, 0);
      pop_expect(8'h41, "R5 stale head");
      chk("R5 empty stays", empty_o, 1);
      chk("R5 free stays", free_o, 1);
   endtask

   task automatic t_mode_flush;
      push_line(8'h33, 3'd0);
      chk("R7 pre flush free", free_o, 0);
      fifo_mode_i = 1; line_push_i = 1; line_data_i = 8'h55;
      step();
      line_push_i = 0;
      chk("R7 flush empty", empty_o, 1);
      chk("R7 flush free", free_o, DEPTH);
      chk("R7 irq kept", rx_irq_o, 1);
      pop_i = 1; step(); pop_i = 0;
      chk("R6 empty pop clears irq", rx_irq_o, 0);
   endtask

   task automatic t_fifo_order;
      for (int i = 0; i < DEPTH; i++) push_line(8'(8'h10 + i), 3'(i));
      chk("R3 fifo full", full_o, 1);
      chk("R1 fifo free", free_o, 0);
      push_line(8'hEE, 3'd0);
      chk("R4 fifo drop", free_o, 0);
      for (int i = 0; i < DEPTH; i++) begin
         pop_expect(8'(8'h10 + i), "R2 order");
         chk("R10 status copy", rsr_o, i % 8);
      end
      chk("R3 fifo empty", empty_o, 1);
      chk("R6 irq after drain", rx_irq_o, 0);
   endtask

   task automatic t_wrap;
      for (int i = 0; i < 5; i++) push_line(8'(8'h60 + i), 3'd0);
      for (int i = 0; i < 5; i++) pop_expect(8'(8'h60 + i), "R2 pre wrap");
      for (int i = 0; i < 14; i++) push_line(8'(8'h70 + i), 3'd0);
      chk("R1 wrap free", free_o, 2);
      for (int i = 0; i < 14; i++) pop_expect(8'(8'h70 + i), "R2 wrap order");
      chk("R3 wrap empty", empty_o, 1);
   endtask

   task automatic t_irq_level;
      push_line(8'h01, 3'd0);
      chk("R6 set at level", rx_irq_o, 1);
      push_line(8'h02, 3'd0);
      chk("R6 held above level", rx_irq_o, 1);
      pop_expect(8'h01, "R6 head");
      chk("R6 held at one left", rx_irq_o, 1);
      pop_expect(8'h02, "R6 head2");
      chk("R6 cleared at zero", rx_irq_o, 0);
   endtask

   task automatic t_simul;
      for (int i = 0; i < DEPTH; i++) push_line(8'(8'hA0 + i), 3'd0);
      chk("R11 head", rd_data_o, 8'hA0);
      line_push_i = 1; line_data_i = 8'h99; pop_i = 1;
      step();
      line_push_i = 0; pop_i = 0;
      chk("R11 still full", full_o, 1);
      chk("R11 free", free_o, 0);
      for (int i = 1; i < DEPTH; i++) pop_expect(8'(8'hA0 + i), "R11 order");
      pop_expect(8'h99, "R11 last");
      chk("R11 empty", empty_o, 1);
   endtask

   task automatic t_loopback;
      tx_push_i = 1; tx_data_i = 8'hC3; step(); tx_push_i = 0;
      chk("R8 tx ignored without loopback", free_o, DEPTH);
      loopback_i = 1;
      push_line(8'h77, 3'd7);
      line_brk_i = 1; step(); line_brk_i = 0;
      chk("R8 line ignored", free_o, DEPTH);
      tx_push_i = 1; tx_data_i = 8'h5A; step(); tx_push_i = 0;
      chk("R8 tx stored", free_o, DEPTH - 1);
      pop_expect(8'h5A, "R8 tx data");
      chk("R8 tx flags zero", rsr_o, 0);
      loopback_i = 0;
   endtask

   task automatic t_break_status;
      line_brk_i = 1; line_push_i = 1; line_data_i = 8'h12;
      step();
      line_brk_i = 0; line_push_i = 0;
      chk("R9 one entry", free_o, DEPTH - 1);
      pop_expect(8'h00, "R9 break data");
      chk("R9 R10 break flag", rsr_o, 4'h8);
      chk("R9 char dropped", empty_o, 1);
      rsr_clr_i = 1; step(); rsr_clr_i = 0;
      chk("R10 clear", rsr_o, 0);
      push_line(8'h3C, 3'b101);
      chk("R10 head", rd_data_o, 8'h3C);
      pop_i = 1; rsr_clr_i = 1; step(); pop_i = 0; rsr_clr_i = 0;
      chk("R10 clear wins", rsr_o, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      t_reset_state();
      t_single_slot();
      t_mode_flush();
      t_fifo_order();
      t_wrap();
      t_irq_level();
      t_simul();
      t_loopback();
      t_break_status();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule